// File: doc/BRIEF.md
# Decimal Ten's-Complement Spike Converter

This block converts a multi-digit decimal operand, presented as unary spike trains with one lane per digit, into the ten's complement of that operand. The output uses the same one-lane-per-digit unary form. A start pulse arms a burst generator that sends ten spikes into the least significant lane and nine spikes into every other lane. Each operand spike is delayed by one register and then meets the burst. When an operand spike and a burst spike land on the same lane in the same cycle, they cancel. A counter per lane therefore keeps 9 − b, or 10 − b on the lowest lane. In this way the "+1" of the ten's complement comes from the longer burst on the lowest lane, with no separate increment step.

When the start pulse has travelled through a fixed delay, the stored counts are fired. Each lane replays its count as serial spikes, one spike per cycle. If the lowest lane has reached ten, it stays silent and passes one extra spike to the next lane up. A second delay line then produces a flag pulse for the adder stage that follows. When the mode input selects addition at start, the burst generator stays idle and the operand digits pass through unchanged. The operand's spikes must start in the same cycle as the start pulse, one spike per cycle per lane.

Top module: `ten_cmp_spike`

## Requirements
- R1: In subtract mode (add_mode=0 at start), every lane receives a burst, one spike per cycle from the cycle after start. The burst is 10 spikes on lane 0 (least significant) and 9 spikes on each other lane. For an all-zero operand the result is lane 0 = 0, lane 1 = 10, and every higher lane = 9.
- R2: Operand spikes are registered once before counting. The operand spikes for a digit b are driven on cycles 0..b−1, where cycle 0 is the start cycle. These spikes coincide with the first b burst spikes.
- R3: A burst spike and an operand spike on the same lane in the same cycle cancel each other. Lane i>0 then holds 9 − b_i, and lane 0 holds 10 − b_0. No lane counter ever exceeds 10.
- R4: With add_mode=1 at start, no burst spikes are generated. Each lane emits exactly b_i spikes.
- R5: The stored counts fire in cycle 11 after start. The output spikes appear one per cycle per lane, starting in cycle 12, and no output spike appears before that.
- R6: If lane 0 holds 10 at firing, lane 0 emits no spikes and lane 1 emits one extra spike.
- R7: flag_out is a single-cycle pulse in cycle 21 after start.
- R8: Every counter clears when it fires. Back-to-back operations spaced 25 cycles apart therefore give independent results.
- R9: rst_n low clears all state at once. After reset no output spikes and no flag appear until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle flag that begins an operation |
| add_mode | input | 1 | 1 = pass operand through (addition), 0 = complement; sampled with start |
| b_spk | input | N_DIG | Operand spike per digit lane, bit 0 least significant |
| out_spk | output | N_DIG | Result spike per digit lane |
| flag_out | output | 1 | Delayed flag toward the adder stage |

## Verification
The corner that matters most is a zero lowest digit. If the carry rule is missing, lane 0 emits ten spikes and lane 1 is one short. An all-nines operand checks that cancellation leaves exactly one spike on lane 0 and silence elsewhere. A misaligned operand delay would instead leave pairs of uncancelled spikes. Addition-mode vectors catch a generator that is not gated off, because it would add nine or ten spikes per lane. A reset applied in the middle of an operation checks that no stale count or flag leaks out afterwards.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  // Burst lengths that realise ten's complement by cancellation
  localparam int unsigned LSD_BURST = 10;
  localparam int unsigned DIG_BURST = 9;

  function automatic int unsigned burst_len(input int unsigned lane);
    return (lane == 0) ? LSD_BURST : DIG_BURST;
  endfunction
endpackage

// File: rtl/tcs_delay.sv
module tcs_delay #(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[DEPTH-1];
endmodule

// File: rtl/tcs_burst_gen.sv
module tcs_burst_gen
  import tcs_pkg::*;
#(
  parameter int unsigned N_DIG = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             enable,
  output logic [N_DIG-1:0] gen_spk
);
  for (genvar g = 0; g < N_DIG; g++) begin : g_lane
    localparam logic [CNT_W-1:0] BURST = CNT_W'(burst_len(g));
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = load || (cnt_q != '0);
      cnt_d  = cnt_q;
      if (load)             cnt_d = enable ? BURST : '0;
      else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign gen_spk[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/tcs_digit_acc.sv
module tcs_digit_acc
  import tcs_pkg::*;
#(
  parameter int unsigned N_DIG = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DIG-1:0]       gen_spk,
  input  logic [N_DIG-1:0]       opd_spk,
  input  logic                   fire,
  output logic [N_DIG*CNT_W-1:0] acc_flat,
  output logic [N_DIG-1:0]       out_spk
);
  localparam logic [CNT_W-1:0] CARRY_LVL = CNT_W'(LSD_BURST);

  logic [CNT_W-1:0] acc_q [N_DIG];
  logic             lsd_carry;

  assign lsd_carry = (acc_q[0] >= CARRY_LVL);

  for (genvar g = 0; g < N_DIG; g++) begin : g_lane
    logic [CNT_W-1:0] acc_d;
    logic             acc_en;
    logic             inc;
    logic [CNT_W-1:0] ocnt_q;
    logic [CNT_W-1:0] ocnt_d;
    logic             ocnt_en;
    logic [CNT_W-1:0] fire_val;

    // coincident burst and operand spikes annihilate
    assign inc = gen_spk[g] ^ opd_spk[g];

    always_comb begin
      acc_en = fire || inc;
      acc_d  = fire ? '0 : acc_q[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q[g] <= '0;
      else if (acc_en) acc_q[g] <= acc_d;
    end

    if (g == 0) begin : g_lsd
      assign fire_val = lsd_carry ? '0 : acc_q[g];
    end else if (g == 1) begin : g_next
      assign fire_val = acc_q[g] + {{(CNT_W-1){1'b0}}, lsd_carry};
    end else begin : g_upper
      assign fire_val = acc_q[g];
    end

    always_comb begin
      ocnt_en = fire || (ocnt_q != '0);
      ocnt_d  = fire ? fire_val : ocnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ocnt_q <= '0;
      else if (ocnt_en) ocnt_q <= ocnt_d;
    end

    assign out_spk[g] = (ocnt_q != '0);
    assign acc_flat[g*CNT_W +: CNT_W] = acc_q[g];
  end
endmodule

// File: rtl/ten_cmp_spike.sv
module ten_cmp_spike
  import tcs_pkg::*;
#(
  parameter int unsigned N_DIG   = 3,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned FWD_DLY = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             add_mode,
  input  logic [N_DIG-1:0] b_spk,
  output logic [N_DIG-1:0] out_spk,
  output logic             flag_out
);
  // fire one cycle after the longest burst has been counted
  localparam int unsigned FIRE_DLY = LSD_BURST + 1;

  logic [N_DIG-1:0]       opd_q;
  logic [N_DIG-1:0]       gen_spk;
  logic                   fire;
  logic [N_DIG*CNT_W-1:0] acc_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opd_q <= '0;
    else        opd_q <= b_spk;
  end

  tcs_burst_gen #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .enable  (!add_mode),
    .gen_spk (gen_spk)
  );

  tcs_delay #(.DEPTH(FIRE_DLY)) u_fire_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (start),
    .dout  (fire)
  );

  tcs_digit_acc #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_spk  (gen_spk),
    .opd_spk  (opd_q),
    .fire     (fire),
    .acc_flat (acc_flat),
    .out_spk  (out_spk)
  );

  tcs_delay #(.DEPTH(FWD_DLY)) u_fwd_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (fire),
    .dout  (flag_out)
  );
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
  parameter int unsigned N_DIG = 3,
  parameter int unsigned CNT_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   add_mode,
  input logic [N_DIG-1:0]       gen_spk,
  input logic                   fire,
  input logic [N_DIG*CNT_W-1:0] acc_flat,
  input logic [N_DIG-1:0]       out_spk,
  input logic                   flag_out
);
  AST_BURST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !add_mode) |=> (gen_spk == '1)); // R1

  AST_GEN_QUIET_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && add_mode) |=> (gen_spk == '0)); // R4

  for (genvar g = 0; g < N_DIG; g++) begin : g_bound
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      acc_flat[g*CNT_W +: CNT_W] <= CNT_W'(10)); // R3
  end

  AST_LSD_CARRY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_flat[CNT_W-1:0] >= CNT_W'(10)) |=> !out_spk[0]); // R6

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_out |=> !flag_out); // R7

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (out_spk == '0 && !flag_out); // R9
    end
  end
endmodule

bind ten_cmp_spike tcs_chk #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .add_mode (add_mode),
  .gen_spk  (gen_spk),
  .fire     (fire),
  .acc_flat (acc_flat),
  .out_spk  (out_spk),
  .flag_out (flag_out)
);

// File: tb/ten_cmp_spike_test.sv
module ten_cmp_spike_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;
  localparam int NVEC = 8;
  localparam int OP_CYC = 25;

  // {add_mode, b2, b1, b0}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd5, 4'd1, 4'd3},
    {1'b0, 4'd9, 4'd9, 4'd9},
    {1'b1, 4'd9, 4'd9, 4'd9},
    {1'b1, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd0, 4'd4, 4'd7},
    {1'b1, 4'd3, 4'd2, 4'd4},
    {1'b0, 4'd2, 4'd9, 4'd0}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          add_mode;
  logic [ND-1:0] b_spk;
  logic [ND-1:0] out_spk;
  logic          flag_out;

  int n_chk;
  int n_fail;
  bit done;

  ten_cmp_spike #(.N_DIG(ND)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .add_mode (add_mode),
    .b_spk    (b_spk),
    .out_spk  (out_spk),
    .flag_out (flag_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dig(input logic [12:0] v, input int lane);
    return int'(v[lane*4 +: 4]);
  endfunction

  function automatic int exp_lane(input logic [12:0] v, input int lane);
    int r;
    if (v[12]) return dig(v, lane);                    // R4
    r = (lane == 0 ? 10 : 9) - dig(v, lane);           // R1 R3
    if (lane == 0 && r >= 10) r = 0;                   // R6
    if (lane == 1 && dig(v, 0) == 0) r = r + 1;        // R6
    return r;
  endfunction

  task automatic run_op(input logic [12:0] v);
    int cnt [ND];
    int first_c;
    int flag_c;
    int flag_n;
    int exp_first;
    first_c = -1; flag_c = -1; flag_n = 0; exp_first = -1;
    for (int l = 0; l < ND; l++) cnt[l] = 0;
    for (int c = 0; c < OP_CYC; c++) begin
      @(negedge clk);
      for (int l = 0; l < ND; l++) if (out_spk[l]) cnt[l]++;
      if (out_spk != '0 && first_c < 0) first_c = c;
      if (flag_out) begin flag_n++; flag_c = c; end
      start    = (c == 0);
      add_mode = v[12];
      for (int l = 0; l < ND; l++) b_spk[l] = (c < dig(v, l));  // R2 alignment
    end
    start = 1'b0; b_spk = '0;
    for (int l = 0; l < ND; l++) begin
      check($sformatf("R3 lane%0d count", l), cnt[l], exp_lane(v, l));
      if (exp_lane(v, l) > 0) exp_first = 12;
    end
    check("R5 first spike cycle", first_c, exp_first);
    check("R7 flag cycle", flag_c, 21);
    check("R7 flag pulses", flag_n, 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; start = 1'b0; add_mode = 1'b0; b_spk = '0;
    repeat (3) @(negedge clk);
    check("R9 reset out_spk", int'(out_spk), 0);
    check("R9 reset flag", int'(flag_out), 0);
    rst_n = 1'b1;

    // table: R1 zero operand, R2/R3 cancellation, R4 pass-through, R6 carry,
    // R8 back-to-back independence
    for (int i = 0; i < NVEC; i++) run_op(VEC[i]);

    // R9: reset in the middle of an operation leaves no residue
    @(negedge clk);
    start = 1'b1; add_mode = 1'b0; b_spk = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-op reset out_spk", int'(out_spk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int spk_seen;
      int flg_seen;
      spk_seen = 0; flg_seen = 0;
      for (int c = 0; c < OP_CYC; c++) begin
        @(negedge clk);
        if (out_spk != '0) spk_seen++;
        if (flag_out) flg_seen++;
      end
      check("R9 no spikes after reset", spk_seen, 0);
      check("R9 no flag after reset", flg_seen, 0);
    end

    // R8: operation after reset is clean
    run_op({1'b0, 4'd1, 4'd2, 4'd5});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule